// File: doc/BRIEF.md
# Two-wire message sequencer

This block runs one complete two-wire bus message on its own. It sits beside a master bus controller that raises a flag with an 8-bit status code after every bus step. For each code the sequencer picks the next step: it writes an address or data byte, asks the controller to continue, or ends the message with a STOP. A host starts a message with a single `msg_go` pulse. The pulse carries the target address (7- or 10-bit), the direction, a byte count and the mode options. Transmit bytes come in through a valid/ready pair. Received bytes leave through a valid strobe.

The message ends with a one-cycle `done` strobe and a two-bit result code. A host may ask for an abort, which takes effect at the next byte boundary. A programmable watchdog does three things. It sets the abort flag when the controller stays silent too long. After a second silent period it resets the controller and ends the message. Its count restarts on every status event.

Top module: `twi_msg_seq`

## Requirements
- R1: With 7-bit addressing, the status 0x08 or 0x10 causes a data write (`dat_wr`) of `{msg_addr[6:0], dir}` together with a control write that has ack=1 and ie=1.
- R2: With 10-bit addressing, the first address byte is `8'hF0 | msg_addr[9:8]<<1 | dir`. The status 0x18 (write) or 0x40 (read) then causes a data write of `msg_addr[7:0]`.
- R3: The direction bit `dir` is `msg_read XOR msg_rev`.
- R4: On 0x18 (7-bit), 0xD0 or 0x28, the block ends with STOP and result 0 (ok) if no bytes remain. Otherwise it raises `tx_ready` until `tx_valid`, then writes `tx_data` with a control write (ack=1, ie=1).
- R5: A read address ack (0x40 in 7-bit mode, or 0xE0) with bytes left gives a control write with no data. Each 0x50 emits `rx_valid` with `ctl_rdata` and a control write. The ack bit is 0 in every control write from the one at which one byte remains or an abort is pending.
- R6: Status 0x58 emits the last received byte, writes STOP and ends with result 0 (ok).
- R7: A read whose address is acknowledged while the byte count is zero ends at once with STOP.
- R8: Statuses 0x20, 0x30 and 0x48 end the message with STOP and result 1 (no device).
- R9: Any other status during a message pulses `ctl_rst`, writes STOP and ends with result 2 (I/O error).
- R10: A status while idle produces only a STOP control write: no `done`, no received byte, and `busy` stays 0. `busy` is high from the cycle after `msg_go` until the cycle of `done`.
- R11: In skip-start mode a write raises `tx_ready` in the cycle after `msg_go` without any control write. A read issues a control write with start=0 and then waits for 0x50 or 0x58.
- R12: An `abort_req` during a write ends the message with STOP, result 0, at the next write ack after at least one byte. During a read it forces ack=0.
- R13: When `tout_limit`+1 cycles pass with no status, the abort flag is set and the final result becomes 3 (timeout). A second such period pulses `ctl_rst` and ends with `done`, result 3. `msg_go` to `done` then takes 2·`tout_limit`+2 cycles.
- R14: The START control write carries start=1, ack=1, ie=1. Every STOP control write carries ie=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_go | input | 1 | Start a message (taken while idle) |
| msg_addr | input | 10 | Target address |
| msg_read | input | 1 | 1 = read message |
| msg_ten | input | 1 | 10-bit addressing |
| msg_rev | input | 1 | Invert direction bit |
| msg_nostart | input | 1 | Skip START and address phases |
| msg_len | input | LEN_W | Byte count |
| abort_req | input | 1 | Request a graceful abort |
| tout_limit | input | TO_W | Watchdog period in cycles |
| ctl_evt | input | 1 | Controller flag event, status valid |
| ctl_status | input | 8 | Controller status code |
| ctl_rdata | input | 8 | Controller received byte |
| ctl_wr | output | 1 | Control write strobe |
| ctl_start | output | 1 | Control write: START |
| ctl_stop | output | 1 | Control write: STOP |
| ctl_ack | output | 1 | Control write: acknowledge enable |
| ctl_ie | output | 1 | Control write: flag interrupt enable |
| ctl_rst | output | 1 | Controller reset pulse |
| dat_wr | output | 1 | Data byte write strobe |
| dat_out | output | 8 | Data byte for the controller |
| tx_valid | input | 1 | Transmit byte valid |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Sequencer wants a transmit byte |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | Message in progress |
| done | output | 1 | Message finished strobe |
| result | output | 2 | 0 ok, 1 no device, 2 I/O error, 3 timeout |

## Verification
Writes and reads are tried with 7-bit and 10-bit targets, with and without the reversed-direction flag. These runs separate the address framing paths and the direction inversion. Read lengths of zero, one and three bytes show when the ack bit is withdrawn. Skip-start transfers and error statuses (missing device, arbitration loss) cover the other entry paths and the two failure exits. Abort requests, a timeout in mid-message and a fully silent controller separate the graceful byte-boundary exit from the two-stage watchdog escalation and its exact cycle count.

// File: rtl/twi_seq_pkg.sv
// Shared constants and types for the two-wire message sequencer.
// Assumes the controller uses the standard status code set.
package twi_seq_pkg;
    localparam logic [7:0] ST_START     = 8'h08;
    localparam logic [7:0] ST_RESTART   = 8'h10;
    localparam logic [7:0] ST_WADDR_ACK = 8'h18;
    localparam logic [7:0] ST_WADDR_NAK = 8'h20;
    localparam logic [7:0] ST_WDATA_ACK = 8'h28;
    localparam logic [7:0] ST_WDATA_NAK = 8'h30;
    localparam logic [7:0] ST_RADDR_ACK = 8'h40;
    localparam logic [7:0] ST_RADDR_NAK = 8'h48;
    localparam logic [7:0] ST_RDATA_ACK = 8'h50;
    localparam logic [7:0] ST_RDATA_NAK = 8'h58;
    localparam logic [7:0] ST_WADDR2_ACK = 8'hD0;
    localparam logic [7:0] ST_RADDR2_ACK = 8'hE0;

    localparam int ADDR_W = 10;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {RES_OK, RES_NODEV, RES_IOERR, RES_TIMEOUT} res_t;
    typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_TXWAIT} phase_t;
    typedef enum logic [3:0] {
        ACT_NONE, ACT_START, ACT_ADDR1, ACT_ADDR2, ACT_FETCH, ACT_SEND,
        ACT_CONT, ACT_RECV, ACT_RECV_STOP, ACT_STOP, ACT_NODEV,
        ACT_FAULT, ACT_IDLESTOP, ACT_HANG
    } act_t;
endpackage

// File: rtl/twi_addr_frame.sv
// Builds the one or two address bytes of a message from the target
// address and mode flags. Purely combinational; assumes 10-bit targets
// use the reserved 11110xx prefix.
module twi_addr_frame
    import twi_seq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              read,
    input  logic              rev,
    input  logic              ten,
    output logic [BYTE_W-1:0] first,
    output logic [BYTE_W-1:0] second
);
    logic dir;

    // Direction bit and address byte selection.
    always_comb begin
        dir    = read ^ rev;
        first  = ten ? {5'b11110, addr[9:8], dir} : {addr[6:0], dir};
        second = addr[7:0];
    end
endmodule

// File: rtl/twi_timeout.sv
// Silence watchdog: counts cycles while running. It fires when the
// count equals the limit and then restarts. A clear has priority and
// suppresses firing in the same cycle.
module twi_timeout #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clr,
    input  logic [TO_W-1:0] limit,
    output logic            expire
);
    logic [TO_W-1:0] cnt;

    assign expire = run && !clr && (cnt == limit);

    // Cycle counter with clear and self-restart.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (clr || expire)  cnt <= '0;
        else if (run)            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/twi_msg_seq.sv
// Two-wire message sequencer top. It reacts to controller status events
// and drives control and data writes for one message. Assumes the
// controller raises ctl_evt for a single cycle per bus step and does
// not raise it again until the sequencer has written back.
module twi_msg_seq
    import twi_seq_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int TO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_go,
    input  logic [ADDR_W-1:0] msg_addr,
    input  logic              msg_read,
    input  logic              msg_ten,
    input  logic              msg_rev,
    input  logic              msg_nostart,
    input  logic [LEN_W-1:0]  msg_len,
    input  logic              abort_req,
    input  logic [TO_W-1:0]   tout_limit,
    input  logic              ctl_evt,
    input  logic [7:0]        ctl_status,
    input  logic [7:0]        ctl_rdata,
    output logic              ctl_wr,
    output logic              ctl_start,
    output logic              ctl_stop,
    output logic              ctl_ack,
    output logic              ctl_ie,
    output logic              ctl_rst,
    output logic              dat_wr,
    output logic [7:0]        dat_out,
    input  logic              tx_valid,
    input  logic [7:0]        tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [7:0]        rx_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    phase_t            phase;
    act_t              act;
    res_t              res_q;
    logic              ten_q, moved, aborting, to_stage, ack_on;
    logic [LEN_W-1:0]  left, cur_left, left_dec;
    logic [BYTE_W-1:0] a1_q, a2_q, a1_n, a2_n;
    logic              cur_ack_on, cur_abort, ack_next;
    logic              idle_go, to_clr, to_exp;
    res_t              fin_ok;

    assign busy     = (phase != PH_IDLE);
    assign tx_ready = (phase == PH_TXWAIT);
    assign result   = res_q;
    assign idle_go  = (phase == PH_IDLE) && msg_go;
    assign to_clr   = idle_go || ctl_evt;

    twi_addr_frame u_frame (
        .addr(msg_addr), .read(msg_read), .rev(msg_rev), .ten(msg_ten),
        .first(a1_n), .second(a2_n)
    );

    twi_timeout #(.TO_W(TO_W)) u_tout (
        .clk(clk), .rst_n(rst_n), .run(busy), .clr(to_clr),
        .limit(tout_limit), .expire(to_exp)
    );

    // Operands seen by the ack rule: fresh message values when starting.
    always_comb begin
        cur_left   = (phase == PH_IDLE) ? msg_len : left;
        cur_ack_on = (phase == PH_IDLE) ? 1'b1 : ack_on;
        cur_abort  = (phase == PH_IDLE) ? 1'b0 : aborting;
        left_dec   = left - ONE;
        fin_ok     = to_stage ? RES_TIMEOUT : RES_OK;
        if (act == ACT_RECV) ack_next = ack_on && !(left_dec == ONE || aborting);
        else                 ack_next = cur_ack_on && !(cur_left == ONE || cur_abort);
    end

    // Action decoder: picks the next step from phase and status code.
    always_comb begin
        act = ACT_NONE;
        if (phase == PH_IDLE) begin
            if (msg_go)       act = msg_nostart ? (msg_read ? ACT_CONT : ACT_FETCH) : ACT_START;
            else if (ctl_evt) act = ACT_IDLESTOP;
        end else if (to_exp && to_stage) begin
            act = ACT_HANG;
        end else if (phase == PH_TXWAIT) begin
            if (tx_valid) act = ACT_SEND;
        end else if (ctl_evt) begin
            case (ctl_status)
                ST_START, ST_RESTART: act = ACT_ADDR1;
                ST_WADDR_ACK, ST_WADDR2_ACK, ST_WDATA_ACK:
                    if (ctl_status == ST_WADDR_ACK && ten_q) act = ACT_ADDR2;
                    else if (left == '0 || (aborting && moved)) act = ACT_STOP;
                    else act = ACT_FETCH;
                ST_RADDR_ACK, ST_RADDR2_ACK:
                    if (ctl_status == ST_RADDR_ACK && ten_q) act = ACT_ADDR2;
                    else if (left == '0) act = ACT_STOP;
                    else act = ACT_CONT;
                ST_RDATA_ACK: act = ACT_RECV;
                ST_RDATA_NAK: act = ACT_RECV_STOP;
                ST_WADDR_NAK, ST_WDATA_NAK, ST_RADDR_NAK: act = ACT_NODEV;
                default: act = ACT_FAULT;
            endcase
        end
    end

    // Action executor: registered controller writes, streams and state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;  res_q <= RES_OK;
            ten_q <= 1'b0;  moved <= 1'b0;  aborting <= 1'b0;
            to_stage <= 1'b0;  ack_on <= 1'b1;  left <= '0;
            a1_q <= '0;  a2_q <= '0;  dat_out <= '0;  rx_data <= '0;
            ctl_wr <= 1'b0;  ctl_start <= 1'b0;  ctl_stop <= 1'b0;
            ctl_ack <= 1'b0;  ctl_ie <= 1'b0;  ctl_rst <= 1'b0;
            dat_wr <= 1'b0;  rx_valid <= 1'b0;  done <= 1'b0;
        end else begin
            ctl_wr <= 1'b0;  ctl_start <= 1'b0;  ctl_stop <= 1'b0;
            ctl_ack <= 1'b0;  ctl_ie <= 1'b0;  ctl_rst <= 1'b0;
            dat_wr <= 1'b0;  rx_valid <= 1'b0;  done <= 1'b0;
            if (busy && abort_req) aborting <= 1'b1;
            if (to_exp && !to_stage) begin
                to_stage <= 1'b1;
                aborting <= 1'b1;
            end
            if (idle_go) begin
                ten_q <= msg_ten;  a1_q <= a1_n;  a2_q <= a2_n;
                left <= msg_len;  moved <= 1'b0;  aborting <= 1'b0;
                to_stage <= 1'b0;  ack_on <= 1'b1;
            end
            case (act)
                ACT_START: begin
                    ctl_wr <= 1'b1; ctl_start <= 1'b1; ctl_ack <= 1'b1; ctl_ie <= 1'b1;
                    phase <= PH_RUN;
                end
                ACT_ADDR1, ACT_ADDR2: begin
                    dat_wr <= 1'b1;  dat_out <= (act == ACT_ADDR1) ? a1_q : a2_q;
                    ctl_wr <= 1'b1;  ctl_ack <= ack_on;  ctl_ie <= 1'b1;
                end
                ACT_FETCH: phase <= PH_TXWAIT;
                ACT_SEND: begin
                    dat_wr <= 1'b1;  dat_out <= tx_data;
                    ctl_wr <= 1'b1;  ctl_ack <= ack_on;  ctl_ie <= 1'b1;
                    left <= left_dec;  moved <= 1'b1;  phase <= PH_RUN;
                end
                ACT_CONT, ACT_RECV: begin
                    ctl_wr <= 1'b1;  ctl_ack <= ack_next;  ctl_ie <= 1'b1;
                    ack_on <= ack_next;  phase <= PH_RUN;
                    if (act == ACT_RECV) begin
                        rx_valid <= 1'b1;  rx_data <= ctl_rdata;
                        left <= left_dec;  moved <= 1'b1;
                    end
                end
                ACT_RECV_STOP, ACT_STOP, ACT_NODEV, ACT_FAULT: begin
                    ctl_wr <= 1'b1;  ctl_stop <= 1'b1;
                    done <= 1'b1;  phase <= PH_IDLE;
                    res_q <= (act == ACT_NODEV) ? RES_NODEV :
                             (act == ACT_FAULT) ? RES_IOERR : fin_ok;
                    if (act == ACT_FAULT) ctl_rst <= 1'b1;
                    if (act == ACT_RECV_STOP) begin
                        rx_valid <= 1'b1;  rx_data <= ctl_rdata;  left <= left_dec;
                    end
                end
                ACT_IDLESTOP: begin
                    ctl_wr <= 1'b1;  ctl_stop <= 1'b1;
                end
                ACT_HANG: begin
                    ctl_rst <= 1'b1;  done <= 1'b1;
                    res_q <= RES_TIMEOUT;  phase <= PH_IDLE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/twi_msg_seq_chk.sv
// Protocol checker for the sequencer's outputs, bound into every
// instance of the top. Observes ports only.
module twi_msg_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic ctl_wr,
    input logic ctl_start,
    input logic ctl_stop,
    input logic ctl_ack,
    input logic ctl_ie,
    input logic ctl_rst,
    input logic dat_wr,
    input logic tx_ready,
    input logic tx_valid,
    input logic rx_valid
);
    // R14
    start_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_start) |-> (ctl_ie && ctl_ack && !ctl_stop));
    // R14
    stop_no_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_stop) |-> !ctl_ie);
    // R4
    done_ends_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((ctl_wr && ctl_stop) || ctl_rst));
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R10
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_valid) |=> (tx_ready || done));
    // R5
    rx_in_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(busy));
    // R9
    reset_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst |-> done);
    // R11
    data_with_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr |-> (ctl_wr && !ctl_stop));
endmodule

bind twi_msg_seq twi_msg_seq_chk chk_i (.*);

// File: tb/twi_msg_seq_tb.sv
`timescale 1ns/1ps
module twi_msg_seq_tb_top;
    localparam int LEN_W = 8;
    localparam int TO_W  = 16;
    localparam int LIM   = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic msg_go = 0, msg_read = 0, msg_ten = 0, msg_rev = 0, msg_nostart = 0;
    logic [9:0] msg_addr = '0;
    logic [LEN_W-1:0] msg_len = '0;
    logic abort_req = 0;
    logic [TO_W-1:0] tout_limit = TO_W'(LIM);
    logic ctl_evt = 0;
    logic [7:0] ctl_status = '0, ctl_rdata = '0;
    logic ctl_wr, ctl_start, ctl_stop, ctl_ack, ctl_ie, ctl_rst, dat_wr;
    logic [7:0] dat_out, rx_data;
    logic tx_valid = 0;
    logic [7:0] tx_data = '0;
    logic tx_ready, rx_valid, busy, done;
    logic [1:0] result;

    int n_chk = 0, n_fail = 0;
    bit mdl_busy = 0, finished = 0;

    always #2.5 clk = ~clk;

    twi_msg_seq #(.LEN_W(LEN_W), .TO_W(TO_W)) dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference busy state compared on every clock (R10).
    always @(negedge clk) if (rst_n && !finished) chk("R10 busy track", int'(busy), int'(mdl_busy));

    task automatic go(input logic [9:0] a, input bit rd, input bit ten, input bit rev,
                      input bit nost, input int len);
        @(negedge clk);
        msg_addr = a; msg_read = rd; msg_ten = ten; msg_rev = rev;
        msg_nostart = nost; msg_len = LEN_W'(len); msg_go = 1;
        @(posedge clk); #1; msg_go = 0; mdl_busy = 1;
    endtask

    task automatic stat(input logic [7:0] s, input logic [7:0] rd);
        @(negedge clk); ctl_evt = 1; ctl_status = s; ctl_rdata = rd;
        @(posedge clk); #1; ctl_evt = 0;
    endtask

    task automatic feed(input string req, input logic [7:0] b);
        @(negedge clk); tx_valid = 1; tx_data = b;
        @(posedge clk); #1; tx_valid = 0;
        chk(req, int'(dat_wr), 1); chk(req, int'(dat_out), int'(b));
        chk(req, int'(ctl_wr), 1); chk(req, int'(ctl_ie), 1);
    endtask

    task automatic pulse_abort();
        @(negedge clk); abort_req = 1;
        @(posedge clk); #1; abort_req = 0;
    endtask

    task automatic fin(input string req, input int res);
        chk(req, int'(done), 1); chk(req, int'(result), res);
        chk(req, int'(busy), 0); chk(req, int'(ctl_wr && ctl_stop), 1);
        chk(req, int'(ctl_ie), 0);
        mdl_busy = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("reset busy", int'(busy), 0); chk("reset done", int'(done), 0);
        chk("reset tx_ready", int'(tx_ready), 0); chk("reset ctl_wr", int'(ctl_wr), 0);
        @(negedge clk); rst_n = 1;

        // R1 R4 R14: 7-bit write of two bytes
        go(10'h05A, 0, 0, 0, 0, 2);
        chk("R14 start", int'(ctl_wr && ctl_start && ctl_ack && ctl_ie && !ctl_stop), 1);
        stat(8'h08, 0);
        chk("R1 dat_wr", int'(dat_wr), 1); chk("R1 addr byte", int'(dat_out), 8'hB4);
        stat(8'h18, 0); chk("R4 tx_ready", int'(tx_ready), 1);
        feed("R4 byte0", 8'h11);
        stat(8'h28, 0); chk("R4 tx_ready 2", int'(tx_ready), 1);
        feed("R4 byte1", 8'h22);
        stat(8'h28, 0); fin("R4 end", 0);

        // R3 R5 R6: 7-bit read with reversed direction, 3 bytes
        go(10'h021, 0, 0, 1, 0, 3);
        stat(8'h08, 0); chk("R3 dir inverted", int'(dat_out), 8'h43);
        stat(8'h40, 0);
        chk("R5 cont", int'(ctl_wr), 1); chk("R5 no data", int'(dat_wr), 0); chk("R5 ack3", int'(ctl_ack), 1);
        stat(8'h50, 8'hA1);
        chk("R5 rx", int'(rx_valid), 1); chk("R5 rxdata", int'(rx_data), 8'hA1); chk("R5 ack2", int'(ctl_ack), 1);
        stat(8'h50, 8'hA2); chk("R5 ack last", int'(ctl_ack), 0);
        stat(8'h58, 8'hA3);
        chk("R6 rx last", int'(rx_valid), 1); chk("R6 data", int'(rx_data), 8'hA3); fin("R6 end", 0);

        // R2: 10-bit write
        go(10'h2C7, 0, 1, 0, 0, 1);
        stat(8'h08, 0); chk("R2 first", int'(dat_out), 8'hF4);
        stat(8'h18, 0); chk("R2 second wr", int'(dat_wr), 1); chk("R2 second", int'(dat_out), 8'hC7);
        stat(8'hD0, 0); chk("R4 after D0", int'(tx_ready), 1);
        feed("R4 10b byte", 8'h99);
        stat(8'h28, 0); fin("R4 10b end", 0);

        // R2 R5: 10-bit read, one byte
        go(10'h1FF, 1, 1, 0, 0, 1);
        stat(8'h08, 0); chk("R2 rd first", int'(dat_out), 8'hF3);
        stat(8'h40, 0); chk("R2 rd second", int'(dat_out), 8'hFF);
        stat(8'hE0, 0); chk("R5 one byte ack", int'(ctl_ack), 0); chk("R5 E0 wr", int'(ctl_wr), 1);
        stat(8'h58, 8'h5E); chk("R6 10b rx", int'(rx_data), 8'h5E); fin("R6 10b end", 0);

        // R7: zero-length read
        go(10'h010, 1, 0, 0, 0, 0);
        stat(8'h08, 0); chk("R7 addr", int'(dat_out), 8'h21);
        stat(8'h40, 0); chk("R7 no rx", int'(rx_valid), 0); fin("R7 end", 0);

        // R8: missing device on write and on read
        go(10'h033, 0, 0, 0, 0, 1);
        stat(8'h08, 0); stat(8'h20, 0); fin("R8 wr nodev", 1);
        go(10'h033, 1, 0, 0, 0, 1);
        stat(8'h08, 0); stat(8'h48, 0); fin("R8 rd nodev", 1);

        // R9: unexpected status
        go(10'h044, 0, 0, 0, 0, 1);
        stat(8'h08, 0); stat(8'h38, 0);
        chk("R9 rst", int'(ctl_rst), 1); fin("R9 end", 2);

        // R10: status while idle
        stat(8'h50, 8'h12);
        chk("R10 stop", int'(ctl_wr && ctl_stop), 1); chk("R10 no done", int'(done), 0);
        chk("R10 no rx", int'(rx_valid), 0); chk("R10 idle", int'(busy), 0);

        // R11: skip-start write
        go(10'h000, 0, 0, 0, 1, 2);
        chk("R11 tx_ready", int'(tx_ready), 1); chk("R11 no ctl", int'(ctl_wr), 0);
        feed("R11 byte0", 8'h5C);
        stat(8'h28, 0); feed("R11 byte1", 8'h6D);
        stat(8'h28, 0); fin("R11 wr end", 0);

        // R11: skip-start read
        go(10'h000, 1, 0, 0, 1, 2);
        chk("R11 rd cont", int'(ctl_wr && !ctl_start), 1); chk("R11 rd ack", int'(ctl_ack), 1);
        chk("R11 rd no data", int'(dat_wr), 0);
        stat(8'h50, 8'h31); chk("R11 rx", int'(rx_data), 8'h31); chk("R11 ack off", int'(ctl_ack), 0);
        stat(8'h58, 8'h32); chk("R11 rx2", int'(rx_data), 8'h32); fin("R11 rd end", 0);

        // R12: abort on write after one byte
        go(10'h055, 0, 0, 0, 0, 3);
        stat(8'h08, 0); stat(8'h18, 0); feed("R12 byte", 8'h01);
        pulse_abort();
        stat(8'h28, 0); chk("R12 no fetch", int'(tx_ready), 0); fin("R12 wr end", 0);

        // R12: abort on read withdraws ack
        go(10'h055, 1, 0, 0, 0, 4);
        stat(8'h08, 0); pulse_abort();
        stat(8'h40, 0); chk("R12 ack off", int'(ctl_ack), 0);
        stat(8'h58, 8'h77); chk("R12 rx", int'(rx_data), 8'h77); fin("R12 rd end", 0);

        // R13: first timeout, then message completes
        go(10'h012, 1, 0, 0, 0, 3);
        stat(8'h08, 0);
        repeat (30) @(negedge clk);
        stat(8'h40, 0); chk("R13 ack off", int'(ctl_ack), 0);
        stat(8'h58, 8'h44); fin("R13 late end", 3);

        // R13: silent controller escalates
        go(10'h012, 0, 0, 0, 0, 1);
        begin
            int n = 0;
            for (int i = 0; i < 1000; i++) begin
                @(posedge clk); #1; n++;
                if (done) break;
            end
            mdl_busy = 0;
            chk("R13 cycles", n, 2 * LIM + 2);
            chk("R13 rst", int'(ctl_rst), 1); chk("R13 result", int'(result), 3);
            chk("R13 idle", int'(busy), 0);
        end

        repeat (3) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule